// File: doc/BRIEF.md
# Debug Control and Status Register with Imprecise-Error Deferral

This block keeps a processor's debug control and status word. When the core enters debug mode it records the cause of the entry. When an exception occurs inside debug mode it records the exception code. It also records whether the faulting instruction sat in a branch delay slot. Capability fields, such as the version, the single-step capability and the memory-segment configuration, come from static straps. The word is presented in full on a 32-bit output so that the core can read it as a coprocessor register. Software writes reach only a small set of writable fields.

The block also owns four sticky pending flags for imprecise errors: data bus error, cache error, machine check and fetch bus error. An inhibit bit holds these errors back while debug software runs. The inhibit bit is set on every debug entry and on every exception taken in debug mode. The debug-return pulse clears it. Once the inhibit bit is clear, the held errors are raised towards the core one at a time, in a fixed priority order. Each request carries its exception code. A flag is dropped when the core acknowledges its request.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset the following fields read 0: cause bits 0-5, bits 18-19, inhibit bit 20, pending bits 21-24, single-step enable bit 8, count-in-debug bit 25, code bits 10-14, delay-slot bit 31 and debug-mode bit 30. Bits 6-7 always read 0. Bit 9 shows `strap_nosst`, bits 15-17 show `strap_ver`, and bits 26-29 show `strap_cfg` (bit 26+k holds `strap_cfg[k]`). After reset `dm` and `imp_req` are 0.
- R2: An `entry_vld` pulse while debug mode is off takes effect one cycle later:
  - bit 30 and `dm` go to 1, and inhibit bit 20 goes to 1;
  - bit 31 takes `entry_dly`;
  - exactly one cause bit is set and the other seven are cleared. Cause codes 0 to 5 (single-step, breakpoint instruction, data-break load, data-break store, instruction break, debug interrupt) select bits 0 to 5. Code 6 (imprecise load break) selects bit 18 and code 7 (imprecise store break) selects bit 19.
- R3: An `exc_vld` pulse while in debug mode takes effect one cycle later:
  - bits 0-5 and 18-19 are cleared;
  - `exc_code` is loaded into bits 10-14;
  - inhibit is set, bit 31 takes `exc_dly`, and debug mode stays on.
  
  `exc_vld` outside debug mode, and `entry_vld` inside it, change nothing.
- R4: A `dret` pulse in debug mode, without `exc_vld` in the same cycle, clears debug mode and the inhibit bit one cycle later. The cause bits are kept.
- R5: Pending bit 21+k is set one cycle after `err_evt[k]` is pulsed, or after a software write with bit 21+k at 1. The order is k=0 data bus error, k=1 cache error, k=2 machine check, k=3 fetch bus error. Writing 0 to a pending bit does not clear it.
- R6: While inhibit bit 20 is 1, `imp_req` is 0 whatever the pending flags hold.
- R7: While inhibit is 0 and any pending flag is set, `imp_req` is 1 in the same cycle, and `imp_code` names one set flag. The flags are ranked machine check (code 24), then cache error (30), then fetch bus error (6), then data bus error (7).
- R8: `imp_ack` while `imp_req` is 1 clears only the flag named by `imp_code`, one cycle later.
- R9: A software write changes only the following fields; all other bits ignore the write:
  - single-step enable bit 8, which reads 0 whenever `strap_nosst` is 1;
  - count-in-debug bit 25;
  - inhibit bit 20, and only while in debug mode;
  - the pending flags, as set out in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_vld | input | 1 | Debug exception taken (pulse) |
| entry_cause | input | 3 | Cause code of the debug exception |
| entry_dly | input | 1 | Debug exception instruction was in a delay slot |
| exc_vld | input | 1 | Exception taken while in debug mode (pulse) |
| exc_code | input | 5 | Code of the exception in debug mode |
| exc_dly | input | 1 | Exception instruction was in a delay slot |
| dret | input | 1 | Return from debug mode (pulse) |
| err_evt | input | 4 | Imprecise error strobes: dbus, cache, mcheck, fetch |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| strap_nosst | input | 1 | Single-step not available |
| strap_ver | input | 3 | Debug version encoding |
| strap_cfg | input | 4 | Static halt, doze, segment control, no-segment flags |
| imp_ack | input | 1 | Core takes the requested imprecise exception |
| dreg | output | 32 | Register value |
| imp_req | output | 1 | Imprecise exception request |
| imp_code | output | 5 | Exception code of the request |
| dm | output | 1 | Debug mode flag |

## Verification
A corrupted pending flag or a wrong inhibit bit shows at `imp_req` in the same cycle. It also shows in `dreg` bits 20-24 one cycle after the stimulus that caused it. A priority or code error appears as a wrong `imp_code` on the first request after a debug return. A flag cleared by the wrong acknowledge shows in `dreg` one cycle after `imp_ack`. Errors in the cause tracking appear in `dreg` one cycle after the entry, exception or return pulse. The bench sweeps every cause code and every non-empty combination of pending flags, so each such error is seen.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned DREG_W  = 32;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned VER_W   = 3;
  localparam int unsigned CFG_W   = 4;
  localparam int unsigned N_CAUSE = 8;
  localparam int unsigned CAUSE_W = $clog2(N_CAUSE);
  localparam int unsigned N_ERR   = 4;
  localparam int unsigned ERR_W   = $clog2(N_ERR);
  localparam int unsigned N_PREC  = 6;

  // bit positions decoded by the core
  localparam int unsigned B_SST   = 8;
  localparam int unsigned B_NOSST = 9;
  localparam int unsigned B_CODE  = 10;
  localparam int unsigned B_VER   = 15;
  localparam int unsigned B_IMPBK = 18;
  localparam int unsigned B_INH   = 20;
  localparam int unsigned B_PEND  = 21;
  localparam int unsigned B_CNT   = 25;
  localparam int unsigned B_CFG   = 26;
  localparam int unsigned B_DM    = 30;
  localparam int unsigned B_DBD   = 31;

  // imprecise error index within the pending field
  localparam int unsigned E_DBUS  = 0;
  localparam int unsigned E_CACHE = 1;
  localparam int unsigned E_MCHK  = 2;
  localparam int unsigned E_FETCH = 3;

  function automatic logic [CODE_W-1:0] err_code(input int unsigned idx);
    case (idx)
      E_DBUS:  err_code = CODE_W'(7);
      E_CACHE: err_code = CODE_W'(30);
      E_MCHK:  err_code = CODE_W'(24);
      default: err_code = CODE_W'(6);
    endcase
  endfunction

  // lower rank is released first
  function automatic int unsigned err_rank(input int unsigned idx);
    case (idx)
      E_MCHK:  err_rank = 0;
      E_CACHE: err_rank = 1;
      E_FETCH: err_rank = 2;
      default: err_rank = 3;
    endcase
  endfunction
endpackage

// File: rtl/dbg_cause_trk.sv
module dbg_cause_trk
  import dbg_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entry_vld,
  input  logic [CAUSE_W-1:0] entry_cause,
  input  logic               entry_dly,
  input  logic               exc_vld,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic               exc_dly,
  input  logic               dret,
  input  logic               sw_we,
  input  logic               sw_inh,
  input  logic               sw_sst,
  input  logic               sw_cnt,
  output logic               dm_q,
  output logic               inh_q,
  output logic [N_CAUSE-1:0] cause_q,
  output logic [CODE_W-1:0]  code_q,
  output logic               dbd_q,
  output logic               sst_q,
  output logic               cnt_q
);
  logic               take_entry, take_exc, take_ret;
  logic               dm_en, inh_en, cause_en, code_en, dbd_en;
  logic               dm_n, inh_n, dbd_n;
  logic [N_CAUSE-1:0] cause_n;

  always_comb begin
    take_entry = entry_vld & ~dm_q;
    take_exc   = exc_vld & dm_q;
    take_ret   = dret & dm_q & ~take_exc;

    dm_en  = take_entry | take_ret;
    dm_n   = take_entry;

    inh_en = take_entry | take_exc | take_ret | (sw_we & dm_q);
    if (take_entry || take_exc) inh_n = 1'b1;
    else if (take_ret)          inh_n = 1'b0;
    else                        inh_n = sw_inh;

    cause_en = take_entry | take_exc;
    cause_n  = take_entry ? (N_CAUSE'(1) << entry_cause) : '0;

    code_en = take_exc;
    dbd_en  = take_entry | take_exc;
    dbd_n   = take_entry ? entry_dly : exc_dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q    <= 1'b0;
      inh_q   <= 1'b0;
      cause_q <= '0;
      code_q  <= '0;
      dbd_q   <= 1'b0;
      sst_q   <= 1'b0;
      cnt_q   <= 1'b0;
    end else begin
      if (dm_en)    dm_q    <= dm_n;
      if (inh_en)   inh_q   <= inh_n;
      if (cause_en) cause_q <= cause_n;
      if (code_en)  code_q  <= exc_code;
      if (dbd_en)   dbd_q   <= dbd_n;
      if (sw_we)    sst_q   <= sw_sst;
      if (sw_we)    cnt_q   <= sw_cnt;
    end
  end
endmodule

// File: rtl/dbg_pend_arb.sv
module dbg_pend_arb
  import dbg_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inh,
  input  logic [N_ERR-1:0]  evt,
  input  logic [N_ERR-1:0]  sw_set,
  input  logic              ack,
  output logic [N_ERR-1:0]  pend_q,
  output logic              req,
  output logic [CODE_W-1:0] code
);
  logic [N_ERR-1:0] grant;
  logic [N_ERR-1:0] pend_n;
  int unsigned      best;
  int unsigned      sel;

  always_comb begin
    best = N_ERR;
    sel  = 0;
    for (int i = 0; i < N_ERR; i++) begin
      if (pend_q[i] && (err_rank(i) < best)) begin
        best = err_rank(i);
        sel  = i;
      end
    end
    grant = '0;
    if (best < N_ERR) grant[sel] = 1'b1;
    req  = ~inh & |pend_q;
    code = err_code(sel);
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_flag
    logic set_g, clr_g, en_g;
    always_comb begin
      set_g     = evt[g] | sw_set[g];
      clr_g     = ack & req & grant[g];
      en_g      = set_g | clr_g;
      pend_n[g] = set_g;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q[g] <= 1'b0;
      else if (en_g) pend_q[g] <= pend_n[g];
    end
  end
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               entry_vld,
  input  logic [CAUSE_W-1:0] entry_cause,
  input  logic               entry_dly,
  input  logic               exc_vld,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic               exc_dly,
  input  logic               dret,
  input  logic [N_ERR-1:0]   err_evt,
  input  logic               sw_we,
  input  logic [DREG_W-1:0]  sw_wdata,
  input  logic               strap_nosst,
  input  logic [VER_W-1:0]   strap_ver,
  input  logic [CFG_W-1:0]   strap_cfg,
  input  logic               imp_ack,
  output logic [DREG_W-1:0]  dreg,
  output logic               imp_req,
  output logic [CODE_W-1:0]  imp_code,
  output logic               dm
);
  logic               dm_q, inh_q, dbd_q, sst_q, cnt_q;
  logic [N_CAUSE-1:0] cause_q;
  logic [CODE_W-1:0]  code_q;
  logic [N_ERR-1:0]   pend_q;
  logic [N_ERR-1:0]   sw_set;
  logic               unused_wdata;

  assign sw_set       = sw_we ? sw_wdata[B_PEND +: N_ERR] : '0;
  assign unused_wdata = ^sw_wdata;

  dbg_cause_trk u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_vld   (entry_vld),
    .entry_cause (entry_cause),
    .entry_dly   (entry_dly),
    .exc_vld     (exc_vld),
    .exc_code    (exc_code),
    .exc_dly     (exc_dly),
    .dret        (dret),
    .sw_we       (sw_we),
    .sw_inh      (sw_wdata[B_INH]),
    .sw_sst      (sw_wdata[B_SST]),
    .sw_cnt      (sw_wdata[B_CNT]),
    .dm_q        (dm_q),
    .inh_q       (inh_q),
    .cause_q     (cause_q),
    .code_q      (code_q),
    .dbd_q       (dbd_q),
    .sst_q       (sst_q),
    .cnt_q       (cnt_q)
  );

  dbg_pend_arb u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .inh    (inh_q),
    .evt    (err_evt),
    .sw_set (sw_set),
    .ack    (imp_ack),
    .pend_q (pend_q),
    .req    (imp_req),
    .code   (imp_code)
  );

  always_comb begin
    dreg                          = '0;
    dreg[N_PREC-1:0]              = cause_q[N_PREC-1:0];
    dreg[B_SST]                   = sst_q & ~strap_nosst;
    dreg[B_NOSST]                 = strap_nosst;
    dreg[B_CODE +: CODE_W]        = code_q;
    dreg[B_VER +: VER_W]          = strap_ver;
    dreg[B_IMPBK +: (N_CAUSE-N_PREC)] = cause_q[N_CAUSE-1:N_PREC];
    dreg[B_INH]                   = inh_q;
    dreg[B_PEND +: N_ERR]         = pend_q;
    dreg[B_CNT]                   = cnt_q;
    dreg[B_CFG +: CFG_W]          = strap_cfg;
    dreg[B_DM]                    = dm_q;
    dreg[B_DBD]                   = dbd_q;
  end

  assign dm = dm_q;
endmodule

// File: rtl/dbg_ctl_chk.sv
module dbg_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        entry_vld,
  input logic        exc_vld,
  input logic        dret,
  input logic [3:0]  err_evt,
  input logic        sw_we,
  input logic [31:0] sw_wdata,
  input logic        imp_ack,
  input logic [31:0] dreg,
  input logic        imp_req,
  input logic [4:0]  imp_code,
  input logic        dm
);
  a_r2_entry_sets_dm: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld && !dm |=> dm && dreg[20]);

  a_r3_exc_clears_causes: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld && dm |=> dm && dreg[20] && (dreg[5:0] == 6'd0) && (dreg[19:18] == 2'd0));

  a_r4_return: assert property (@(posedge clk) disable iff (!rst_n)
    dret && dm && !exc_vld |=> !dm && !dreg[20]);

  a_r5_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt != 4'd0 |=> (dreg[24:21] & $past(err_evt)) == $past(err_evt));

  a_r6_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dreg[20] |-> !imp_req);

  a_r7_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    imp_req |-> (dreg[24:21] != 4'd0) && !dreg[20]);

  a_r8_ack_clears_mchk: assert property (@(posedge clk) disable iff (!rst_n)
    imp_req && imp_ack && (imp_code == 5'd24) && !err_evt[2] && !(sw_we && sw_wdata[23])
    |=> !dreg[23]);

  a_r9_inh_locked_outside: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && !dm && !entry_vld |=> $stable(dreg[20]));
endmodule

bind dbg_ctl_reg dbg_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .entry_vld (entry_vld),
  .exc_vld   (exc_vld),
  .dret      (dret),
  .err_evt   (err_evt),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .imp_ack   (imp_ack),
  .dreg      (dreg),
  .imp_req   (imp_req),
  .imp_code  (imp_code),
  .dm        (dm)
);

// File: tb/tb_dbg_ctl_reg.sv
module tb_dbg_ctl_reg;
  localparam time CLK_PER = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_vld, entry_dly, exc_vld, exc_dly, dret, sw_we, imp_ack;
  logic [2:0]  entry_cause;
  logic [4:0]  exc_code;
  logic [3:0]  err_evt;
  logic [31:0] sw_wdata;
  logic        strap_nosst;
  logic [2:0]  strap_ver;
  logic [3:0]  strap_cfg;
  logic [31:0] dreg;
  logic        imp_req, dm;
  logic [4:0]  imp_code;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PER/2) clk = ~clk;

  dbg_ctl_reg dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] strap_bits();
    return (32'(strap_ver) << 15) | (32'(strap_cfg) << 26) | (32'(strap_nosst) << 9);
  endfunction

  function automatic int cause_pos(input int c);
    return (c < 6) ? c : 18 + (c - 6);
  endfunction

  function automatic logic [4:0] ecode(input int idx);
    case (idx)
      0: return 5'd7;
      1: return 5'd30;
      2: return 5'd24;
      default: return 5'd6;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    {entry_vld, entry_dly, exc_vld, exc_dly, dret, sw_we, imp_ack} = '0;
    entry_cause = '0; exc_code = '0; err_evt = '0; sw_wdata = '0;
    repeat (3) @(posedge clk);
    #(CLK_PER/2);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic enter(input int c, input logic d);
    entry_vld = 1'b1; entry_cause = 3'(c); entry_dly = d;
    tick();
    entry_vld = 1'b0;
  endtask

  task automatic leave();
    dret = 1'b1;
    tick();
    dret = 1'b0;
  endtask

  task automatic swr(input logic [31:0] v);
    sw_we = 1'b1; sw_wdata = v;
    tick();
    sw_we = 1'b0;
  endtask

  initial begin
    int order[4];
    logic [3:0] rem;
    logic [31:0] prev;
    order = '{2, 1, 3, 0};

    strap_nosst = 1'b0; strap_ver = 3'd2; strap_cfg = 4'b1010;
    do_reset();
    chk("R1 reset word", dreg, strap_bits());
    chk("R1 reset dm", 32'(dm), 0);
    chk("R1 reset req", 32'(imp_req), 0);

    // R2 / R4: every cause code
    for (int c = 0; c < 8; c++) begin
      enter(c, c[0]);
      chk("R2 dm", 32'(dm), 1);
      chk("R2 word", dreg & 32'hC00C_003F,
          (32'(c[0]) << 31) | (32'd1 << 30) | (32'd1 << cause_pos(c)));
      chk("R2 inhibit", 32'(dreg[20]), 1);
      leave();
      chk("R4 dm off", 32'(dm), 0);
      chk("R4 inhibit off", 32'(dreg[20]), 0);
      chk("R4 cause kept", dreg & 32'h000C_003F, 32'd1 << cause_pos(c));
    end

    // R3: entry ignored in debug mode, exception in debug mode
    enter(1, 1'b0);
    prev = dreg;
    enter(4, 1'b1);
    chk("R3 entry in dm ignored", dreg, prev);
    exc_vld = 1'b1; exc_code = 5'd13; exc_dly = 1'b1;
    tick();
    exc_vld = 1'b0;
    chk("R3 exc word", dreg & 32'hC01C_7C3F, 32'hC010_0000 | (32'd13 << 10));
    leave();
    prev = dreg;
    exc_vld = 1'b1; exc_code = 5'd5; exc_dly = 1'b0;
    tick();
    exc_vld = 1'b0;
    chk("R3 exc outside dm ignored", dreg, prev);

    // R5-R8: every non-empty pending set
    for (int p = 1; p < 16; p++) begin
      enter(0, 1'b0);
      if (p % 2 == 1) begin
        err_evt = 4'(p);
        tick();
        err_evt = '0;
      end else begin
        swr((32'(p) << 21) | (32'd1 << 20));
      end
      chk("R5 pending set", 32'(dreg[24:21]), p);
      chk("R6 no req inhibited", 32'(imp_req), 0);
      tick();
      chk("R6 still held", 32'(imp_req), 0);
      leave();
      rem = 4'(p);
      for (int k = 0; k < 4; k++) begin
        if (rem[order[k]]) begin
          chk("R7 req", 32'(imp_req), 1);
          chk("R7 code", 32'(imp_code), 32'(ecode(order[k])));
          imp_ack = 1'b1;
          tick();
          imp_ack = 1'b0;
          rem[order[k]] = 1'b0;
          chk("R8 flag cleared", 32'(dreg[24:21]), 32'(rem));
        end
      end
      chk("R7 idle", 32'(imp_req), 0);
    end

    // R5: writing zero keeps flags
    enter(2, 1'b0);
    err_evt = 4'b0101;
    tick();
    err_evt = '0;
    swr(32'd1 << 20);
    chk("R5 zero write keeps", 32'(dreg[24:21]), 5);
    leave();
    repeat (2) begin
      imp_ack = 1'b1; tick(); imp_ack = 1'b0;
    end
    chk("R8 drained", 32'(dreg[24:21]), 0);

    // R7: error raised directly when not inhibited
    err_evt = 4'b1000;
    tick();
    err_evt = '0;
    chk("R7 direct req", 32'(imp_req), 1);
    chk("R7 direct code", 32'(imp_code), 6);
    imp_ack = 1'b1; tick(); imp_ack = 1'b0;

    // R9: software write masks
    prev = dreg;
    swr(32'hFE1F_FFFF);
    chk("R9 write outside dm", dreg, prev | (32'd1 << 8) | (32'd1 << 25));
    swr(32'h0);
    chk("R9 write zero", dreg, prev);
    enter(3, 1'b0);
    swr(32'h0);
    chk("R9 inhibit clear in dm", 32'(dreg[20]), 0);
    swr(32'd1 << 20);
    chk("R9 inhibit set in dm", 32'(dreg[20]), 1);
    leave();

    strap_nosst = 1'b1; strap_ver = 3'd1; strap_cfg = 4'b0101;
    do_reset();
    chk("R1 reset alt straps", dreg, strap_bits());
    swr(32'd1 << 8);
    chk("R9 sst blocked", 32'(dreg[8]), 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule